// File: doc/BRIEF.md
# OTG ID-Pin Mode Settling Filter

This block takes the raw ID level from a USB PHY and turns it into a settled host/device mode flag for an on-the-go controller. It runs on the PHY clock. The raw level first crosses into that domain through a two-stage synchronizer. A new candidate mode is adopted only after it has held, unchanged, for a full settling window of `SETTLE_CYCLES` PHY clock cycles. The window is counted by a `CNT_W`-bit counter. With the default of 300,000 cycles the window is about 10 ms at 30 MHz and about 50 ms at 6 MHz.

Software can pin the mode with a force-host or a force-device request. Turning a force on, or turning it off, starts the same settling window that a real ID change starts. The forced mode, or the filtered ID level after a release, shows up only when that window ends. A `busy` flag is high while a window is open, so software can poll for completion instead of waiting a worst-case time.

When the PHY already debounces ID, the build parameter `FILTER_EN = 0` removes the counter. The synchronized level, with any force applied, then reaches the output one register later.

Top module: `id_settle_filter`

## Requirements
- R1: `id_raw` low means host and high means device. `mode_host` is 1 for host and 0 for device.
- R2: While `rst` is high, and in the cycle after it falls, `mode_host` is 0 (device) and `busy` is 0, whatever the level of `id_raw`.
- R3: A new `id_raw` level first sampled on clock edge k opens a window on edge k+2. With the level held, `mode_host` takes the new mode on edge k+2+`SETTLE_CYCLES`.
- R4: `busy` rises on the edge that opens a window and falls on the edge where `mode_host` is updated. Outside a window, `busy` is low and `mode_host` does not change.
- R5: Any change of the candidate (synchronized ID level or force selection) restarts the window from zero. An ID pulse shorter than the window leaves `mode_host` unchanged.
- R6: With `force_host` high, `mode_host` becomes 1 one window after the request, whatever the ID level.
- R7: With `force_device` high and `force_host` low, `mode_host` becomes 0 one window after the request, whatever the ID level.
- R8: With both force inputs high, force-host wins. Adding `force_device` while `force_host` is already held opens no window.
- R9: Releasing a force opens a window. After it, `mode_host` follows the synchronized ID level.
- R10: Entering a force whose mode equals the present `mode_host` still runs a full window (`busy` high) and leaves `mode_host` unchanged.
- R11: With `FILTER_EN = 0`, `mode_host` equals the forced-or-ID candidate three edges after `id_raw` is sampled (one edge after a force input is sampled), and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| id_raw | input | 1 | Unsynchronized ID level from the PHY (0 = host) |
| force_host | input | 1 | Software request to pin host mode |
| force_device | input | 1 | Software request to pin device mode |
| mode_host | output | 1 | Settled mode, 1 = host, 0 = device |
| busy | output | 1 | High while a settling window is in progress |

## Verification
On every cycle the assertions check four things. Each `mode_host` change lands exactly `SETTLE_CYCLES` edges after the last window restart. A restart always raises `busy`. A held force always ends in its mode. The output is device right after reset. Only the bench scenarios can show the rest, because it depends on stimulus order. This covers the glitch that restarts the window without moving the output, the window after a force that matches the present mode, the release of a force back to the ID level, and the case where a second force is added with no effect. The bench compares the filtered and bypass instances against a behavioural model on every clock.

// File: rtl/id_filt_pkg.sv
package id_filt_pkg;

  typedef enum logic [1:0] {
    FRC_NONE   = 2'd0,
    FRC_HOST   = 2'd1,
    FRC_DEVICE = 2'd2
  } force_sel_t;

  typedef struct packed {
    force_sel_t frc;
    logic       host;
  } mode_key_t;

  localparam mode_key_t KEY_RESET = '{frc: FRC_NONE, host: 1'b0};

endpackage

// File: rtl/id_sync_chain.sv
module id_sync_chain #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= RESET_VAL;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RESET_VAL;
          else     stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/mode_request.sv
module mode_request
  import id_filt_pkg::*;
(
  input  logic      id_sync,
  input  logic      force_host,
  input  logic      force_device,
  output mode_key_t key
);
  always_comb begin
    if (force_host) begin
      key.frc  = FRC_HOST;
      key.host = 1'b1;
    end else if (force_device) begin
      key.frc  = FRC_DEVICE;
      key.host = 1'b0;
    end else begin
      key.frc  = FRC_NONE;
      key.host = ~id_sync;
    end
  end
endmodule

// File: rtl/key_tracker.sv
module key_tracker
  import id_filt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  mode_key_t key,
  output mode_key_t key_q,
  output logic      restart
);
  always_ff @(posedge clk) begin
    if (rst) key_q <= KEY_RESET;
    else     key_q <= key;
  end

  assign restart = (key != key_q);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int          CNT_W         = 20,
  parameter int unsigned SETTLE_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic target_host,
  output logic mode_host,
  output logic busy
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
        mode_q <= target_host;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode_host = mode_q;
  assign busy      = busy_q;
endmodule

// File: rtl/id_settle_filter.sv
module id_settle_filter
  import id_filt_pkg::*;
#(
  parameter bit          FILTER_EN     = 1'b1,
  parameter int          CNT_W         = 20,
  parameter int unsigned SETTLE_CYCLES = 300000
) (
  input  logic clk,
  input  logic rst,
  input  logic id_raw,
  input  logic force_host,
  input  logic force_device,
  output logic mode_host,
  output logic busy
);
  logic      id_sync;
  mode_key_t cand_key;
  logic      win_restart;

  id_sync_chain #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (id_raw),
    .d_out (id_sync)
  );

  mode_request u_req (
    .id_sync      (id_sync),
    .force_host   (force_host),
    .force_device (force_device),
    .key          (cand_key)
  );

  generate
    if (FILTER_EN) begin : g_filter
      mode_key_t key_q;

      key_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .key     (cand_key),
        .key_q   (key_q),
        .restart (win_restart)
      );

      settle_timer #(.CNT_W(CNT_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .restart     (win_restart),
        .target_host (key_q.host),
        .mode_host   (mode_host),
        .busy        (busy)
      );
    end else begin : g_bypass
      logic mode_q;
      always_ff @(posedge clk) begin
        if (rst) mode_q <= 1'b0;
        else     mode_q <= cand_key.host;
      end
      assign mode_host   = mode_q;
      assign busy        = 1'b0;
      assign win_restart = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/id_settle_filter_chk.sv
module id_settle_filter_chk #(
  parameter bit          FILTER_EN     = 1'b1,
  parameter int unsigned SETTLE_CYCLES = 300000
) (
  input logic clk,
  input logic rst,
  input logic force_host,
  input logic force_device,
  input logic mode_host,
  input logic busy,
  input logic restart
);
  logic        rst_d;
  int unsigned since_q;
  int unsigned hold_fh_q;
  int unsigned hold_fd_q;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      since_q   <= 0;
      hold_fh_q <= 0;
      hold_fd_q <= 0;
    end else begin
      if (restart) since_q <= 0;
      else if (since_q <= SETTLE_CYCLES) since_q <= since_q + 1;
      if (!force_host) hold_fh_q <= 0;
      else if (hold_fh_q <= SETTLE_CYCLES + 1) hold_fh_q <= hold_fh_q + 1;
      if (!force_device || force_host) hold_fd_q <= 0;
      else if (hold_fd_q <= SETTLE_CYCLES + 1) hold_fd_q <= hold_fd_q + 1;
    end
  end

  // R2: device mode and idle straight after reset
  always_ff @(posedge clk) begin
    if (rst_d) a_r2_reset_device: assert (!mode_host && !busy);
  end

  generate
    if (FILTER_EN) begin : g_filt_props
      a_r4_restart_sets_busy: assert property (@(posedge clk) disable iff (rst)
        restart |=> busy);
      a_r3_update_at_window_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_host) |-> (since_q == SETTLE_CYCLES));
      a_r4_idle_holds_mode: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(mode_host));
      a_r6_force_host_lands: assert property (@(posedge clk) disable iff (rst)
        (hold_fh_q > SETTLE_CYCLES) |-> mode_host);
      a_r7_force_device_lands: assert property (@(posedge clk) disable iff (rst)
        (hold_fd_q > SETTLE_CYCLES) |-> !mode_host);
    end else begin : g_byp_props
      a_r11_bypass_never_busy: assert property (@(posedge clk) disable iff (rst)
        !busy);
      a_r11_bypass_force_host: assert property (@(posedge clk) disable iff (rst)
        (force_host && $past(force_host) && !$past(rst)) |-> mode_host);
    end
  endgenerate
endmodule

bind id_settle_filter id_settle_filter_chk #(
  .FILTER_EN     (FILTER_EN),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .force_host   (force_host),
  .force_device (force_device),
  .mode_host    (mode_host),
  .busy         (busy),
  .restart      (win_restart)
);

// File: tb/sim_id_settle_filter.sv
`timescale 1ns/1ps
module sim_id_settle_filter;
  localparam int SET = 24;
  localparam int LONG = SET + 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_raw = 1'b0;
  logic force_host = 1'b0;
  logic force_device = 1'b0;
  logic mode_f, busy_f, mode_b, busy_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R2";

  always #4 clk = ~clk;

  id_settle_filter #(.FILTER_EN(1'b1), .CNT_W(20), .SETTLE_CYCLES(SET)) u0 (
    .clk(clk), .rst(rst), .id_raw(id_raw), .force_host(force_host),
    .force_device(force_device), .mode_host(mode_f), .busy(busy_f));

  id_settle_filter #(.FILTER_EN(1'b0), .CNT_W(20), .SETTLE_CYCLES(SET)) u1 (
    .clk(clk), .rst(rst), .id_raw(id_raw), .force_host(force_host),
    .force_device(force_device), .mode_host(mode_b), .busy(busy_b));

  // Behavioural reference: window defined by the edge number it opened on
  int cyc = 0;
  int m_s1, m_s2, m_frc, m_want, m_mode, m_busy, m_open, b_mode;
  always @(posedge clk) begin
    int frc, want;
    cyc++;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_frc = 0; m_want = 0;
      m_mode = 0; m_busy = 0; m_open = 0; b_mode = 0;
    end else begin
      frc  = force_host ? 1 : (force_device ? 2 : 0);
      want = force_host ? 1 : (force_device ? 0 : (m_s2 == 1 ? 0 : 1));
      if (frc != m_frc || want != m_want) begin
        m_frc = frc; m_want = want; m_busy = 1; m_open = cyc;
      end else if (m_busy == 1 && cyc - m_open == SET) begin
        m_mode = m_want; m_busy = 0;
      end
      b_mode = want;
      m_s2 = m_s1;
      m_s1 = id_raw ? 1 : 0;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check({phase, " mode"}, mode_f, m_mode[0]);
      check({phase, " busy"}, busy_f, m_busy[0]);
      check("R11 bypass mode", mode_b, b_mode[0]);
      check("R11 bypass busy", busy_b, 1'b0);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    phase = "R2";
    step(5);
    check("R2 reset mode", mode_f, 1'b0);
    check("R2 reset busy", busy_f, 1'b0);
    rst = 1'b0;
    step(1);
    check("R2 post-reset mode", mode_f, 1'b0);

    phase = "R3";
    step(LONG);
    check("R3 host after window", mode_f, 1'b1);
    check("R1 low ID is host", mode_f, 1'b1);

    phase = "R5";
    id_raw = 1'b1;
    step(SET / 2);
    id_raw = 1'b0;
    step(LONG);
    check("R5 glitch ignored", mode_f, 1'b1);

    phase = "R1";
    id_raw = 1'b1;
    step(LONG);
    check("R1 high ID is device", mode_f, 1'b0);

    phase = "R6";
    force_host = 1'b1;
    step(2);
    check("R4 busy mid window", busy_f, 1'b1);
    check("R4 mode held mid window", mode_f, 1'b0);
    step(LONG);
    check("R6 forced host", mode_f, 1'b1);

    phase = "R8";
    force_device = 1'b1;
    step(3);
    check("R8 no window on second force", busy_f, 1'b0);
    check("R8 host wins", mode_f, 1'b1);

    phase = "R7";
    force_host = 1'b0;
    id_raw = 1'b0;
    step(LONG);
    check("R7 forced device over low ID", mode_f, 1'b0);

    phase = "R9";
    force_device = 1'b0;
    step(3);
    check("R9 release opens window", busy_f, 1'b1);
    check("R9 mode held during window", mode_f, 1'b0);
    step(LONG);
    check("R9 follows ID after release", mode_f, 1'b1);

    phase = "R10";
    force_host = 1'b1;
    step(3);
    check("R10 same-mode force busy", busy_f, 1'b1);
    step(LONG);
    check("R10 mode unchanged", mode_f, 1'b1);
    check("R4 idle after window", busy_f, 1'b0);
    force_host = 1'b0;
    step(LONG);

    finish_run();
  end
endmodule